// File: doc/BRIEF.md
# Reed-Solomon GF(2^10) Sector Parity Engine

The engine divides one 512-byte flash sector by a six-root Reed-Solomon generator polynomial over GF(2^10). Every incoming data byte becomes a 10-bit symbol whose two top bits are zero. The field is built from x^10 + x^3 + 1, and the generator has the roots alpha^0 to alpha^5. The first byte of the sector is the highest-degree term. In generate mode the six-symbol remainder is the parity. It is packed into a 64-bit word, and the four spare top bits of that word are set. Each byte of the word is bit-reversed and read through the low byte of a 16-bit register.

In check mode the host first streams the 512 data bytes, then the eight parity bytes exactly as it read them from the register port. The engine reverses and unpacks those bytes and pushes the six parity symbols through the same division, one per cycle. It then reports whether anything is left over. Locating and correcting errors is the job of later logic.

A small finite-state machine sequences the work. Its states are IDLE (after reset), DATA (taking data bytes), PARITY (taking received parity bytes), FEED (pushing the six unpacked symbols) and DONE. The transitions are as follows:
- Any clear moves the machine to DATA.
- In DATA, the 512th accepted byte moves it to DONE in generate mode, or to PARITY in check mode.
- In PARITY, the eighth byte moves it to FEED.
- In FEED, the sixth symbol moves it to DONE.
- DONE holds until the next clear.

Top module: `rs10_parity_engine`

## Requirements
- R1: After reset the control register (address 0) and status register (address 1) read 0. The six remainder registers read 0. ECC bytes 0 to 6 read 0x00 and ECC byte 7 reads 0x0F.
- R2: A write to address 0 with bit 2 (clear) set has three effects on the next edge: it zeroes all six remainder symbols, restarts the byte count, and latches bit 1 as the mode (1 = generate, 0 = check). Bit 0 is the enable bit and bit 1 the generate bit; both read back at those positions. The clear bit reads back as 0.
- R3: In generate mode, after 512 accepted bytes, the register at address 2+k holds the coefficient of x^k of D(x)·x^6 mod g(x), in bits 9:0. Here g(x) is the product of (x + alpha^i) for i = 0 to 5, over GF(2^10) with field polynomial 0x409. D(x) has the first byte as its highest-degree term.
- R4: The packed word carries the coefficient of x^(5-j) in bits 10j+9 to 10j, and bits 63 to 60 are 1. ECC byte i, at address 8+i, is bits 8i+7 to 8i of that word in reversed bit order, in read bits 7:0. Read bits 15:8 are 0.
- R5: The status done bit (bit 1) rises after the 512th byte in generate mode. Further byte strobes in DONE leave the remainder unchanged.
- R6: While the enable bit is 0, byte strobes are ignored and the remainder holds. Setting enable again without clear continues the same sector.
- R7: In check mode, after 512 data bytes and 8 parity bytes in register-port form, the remainder registers hold C(x)·x^6 mod g(x) for the received 518-symbol codeword. A valid codeword leaves the status error bit (bit 0) at 0 when done.
- R8: A single corrupted data byte, or a corrupted non-pad bit of a received parity byte, sets the status error bit to 1 in check mode.
- R9: Bits 3:0 of the eighth received parity byte (the pad) have no effect on the check result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| byte_valid | input | 1 | Data byte strobe |
| byte_data | input | 8 | Data or received parity byte |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 4 | Register address (0 control, 1 status, 2-7 remainder, 8-15 ECC bytes) |
| reg_wdata | input | 16 | Register write data |
| reg_rdata | output | 16 | Register read data for reg_addr |

## Verification
Some behaviour is checked by assertions on every cycle:
- A clear empties the remainder.
- The remainder and the state counter hold while enable is low or after DONE.
- Generate mode never enters PARITY.
- The upper byte of every ECC read is zero, and the pad nibble of the last ECC byte is always set.

The arithmetic can only be shown by the bench's scenarios. It compares the remainder and the bit-reversed packing with a polynomial long-division model, in directed and random sectors. Other scenarios check that a sector continues across a freeze, that a valid codeword gives a clear flag, that corrupted data or parity raises the flag, and that the pad nibble is ignored.

// File: rtl/rsp_pkg.sv
package rsp_pkg;
    parameter int SYM_W = 10;
    parameter int NPAR = 6;
    parameter int DATA_LEN = 512;
    parameter logic [SYM_W:0] FIELD_POLY = 11'h409;
    parameter int FIRST_ROOT = 0;

    localparam int PACK_W = NPAR * SYM_W;
    localparam int ECC_BYTES = (PACK_W + 7) / 8;
    localparam int PACKED_W = ECC_BYTES * 8;

    typedef logic [SYM_W-1:0] sym_t;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_DATA,
        ST_PARITY,
        ST_FEED,
        ST_DONE
    } rsp_state_e;

    function automatic sym_t gf_xtime(sym_t a);
        sym_t s;
        s = {a[SYM_W-2:0], 1'b0};
        if (a[SYM_W-1]) s = s ^ FIELD_POLY[SYM_W-1:0];
        return s;
    endfunction

    function automatic sym_t gf_mul(sym_t a, sym_t b);
        sym_t acc;
        sym_t sh;
        acc = '0;
        sh = a;
        for (int i = 0; i < SYM_W; i++) begin
            if (b[i]) acc = acc ^ sh;
            sh = gf_xtime(sh);
        end
        return acc;
    endfunction

    function automatic sym_t gf_alpha_pow(int n);
        sym_t v;
        v = sym_t'(1);
        for (int i = 0; i < n; i++) v = gf_xtime(v);
        return v;
    endfunction

    // coefficient of x^k in prod (x + alpha^(FIRST_ROOT+i)), i = 0..NPAR-1
    function automatic sym_t rs_gen_coef(int k);
        sym_t g [16];
        sym_t root;
        for (int j = 0; j < 16; j++) g[j] = '0;
        g[0] = sym_t'(1);
        for (int i = 0; i < NPAR; i++) begin
            root = gf_alpha_pow(FIRST_ROOT + i);
            for (int j = NPAR; j > 0; j--) g[j] = g[j-1] ^ gf_mul(g[j], root);
            g[0] = gf_mul(g[0], root);
        end
        return g[k];
    endfunction

    function automatic logic [7:0] rev8(logic [7:0] b);
        logic [7:0] r;
        for (int i = 0; i < 8; i++) r[i] = b[7-i];
        return r;
    endfunction
endpackage

// File: rtl/rsp_divider.sv
module rsp_divider
    import rsp_pkg::*;
#(
    parameter int W = SYM_W,
    parameter int NP = NPAR
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  clr,
    input  logic                  shift_en,
    input  logic [W-1:0]          sym_in,
    output logic [NP-1:0][W-1:0]  rem
);
    logic [NP-1:0][W-1:0] rem_q;
    logic [NP-1:0][W-1:0] rem_d;
    logic [NP-1:0][W-1:0] prod;
    logic [W-1:0]         fb;

    assign fb = sym_in ^ rem_q[NP-1];

    for (genvar k = 0; k < NP; k++) begin : g_tap
        localparam sym_t TAP = rs_gen_coef(k);
        assign prod[k] = gf_mul(fb, TAP);
        if (k == 0) begin : g_first
            assign rem_d[k] = prod[k];
        end else begin : g_rest
            assign rem_d[k] = rem_q[k-1] ^ prod[k];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rem_q <= '0;
        end else if (clr) begin
            rem_q <= '0;
        end else if (shift_en) begin
            rem_q <= rem_d;
        end
    end

    assign rem = rem_q;

    AST_CLEAR_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (rem == '0)); // R2
    AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (!clr && !shift_en) |=> $stable(rem)); // R6
endmodule

// File: rtl/rsp_packer.sv
module rsp_packer
    import rsp_pkg::*;
#(
    parameter int W = SYM_W,
    parameter int NP = NPAR,
    parameter int NB = ECC_BYTES
) (
    input  logic [NP-1:0][W-1:0] rem,
    output logic [NB-1:0][7:0]   ecc_out
);
    localparam int USED_W = NP * W;
    localparam int FULL_W = NB * 8;

    logic [FULL_W-1:0] flat;

    for (genvar j = 0; j < NP; j++) begin : g_slot
        assign flat[j*W +: W] = rem[NP-1-j];
    end

    if (FULL_W > USED_W) begin : g_pad
        assign flat[FULL_W-1:USED_W] = '1;
    end

    for (genvar b = 0; b < NB; b++) begin : g_byte
        assign ecc_out[b] = rev8(flat[b*8 +: 8]);
    end
endmodule

// File: rtl/rsp_parity_buf.sv
module rsp_parity_buf
    import rsp_pkg::*;
#(
    parameter int W = SYM_W,
    parameter int NP = NPAR,
    parameter int NB = ECC_BYTES,
    localparam int BI_W = $clog2(NB),
    localparam int SI_W = $clog2(NP)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            clr,
    input  logic            we,
    input  logic [BI_W-1:0] byte_idx,
    input  logic [7:0]      byte_in,
    input  logic [SI_W-1:0] slot_idx,
    output logic [W-1:0]    slot_sym
);
    logic [NB-1:0][7:0] buf_q;
    logic [NB*8-1:0]    flat;
    logic [W-1:0]       slots [NP];

    for (genvar b = 0; b < NB; b++) begin : g_byte
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                buf_q[b] <= '0;
            end else if (clr) begin
                buf_q[b] <= '0;
            end else if (we && byte_idx == BI_W'(b)) begin
                buf_q[b] <= rev8(byte_in);
            end
        end
    end

    assign flat = buf_q;

    for (genvar j = 0; j < NP; j++) begin : g_slot
        assign slots[j] = flat[j*W +: W];
    end

    assign slot_sym = (slot_idx < SI_W'(NP)) ? slots[slot_idx] : '0;
endmodule

// File: rtl/rsp_ctrl.sv
module rsp_ctrl
    import rsp_pkg::*;
#(
    parameter int NLEN = DATA_LEN,
    parameter int NP = NPAR,
    parameter int NB = ECC_BYTES,
    localparam int CNT_W = $clog2(NLEN),
    localparam int BI_W = $clog2(NB),
    localparam int SI_W = $clog2(NP)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            clr,
    input  logic            enable,
    input  logic            gen_mode,
    input  logic            byte_valid,
    output logic            shift_en,
    output logic            feed_parity,
    output logic            pbuf_we,
    output logic            done,
    output logic [BI_W-1:0] byte_idx,
    output logic [SI_W-1:0] slot_idx
);
    rsp_state_e       state_q, state_d;
    logic [CNT_W-1:0] cnt_q, cnt_d;
    logic             accept;

    assign accept = enable && byte_valid;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
        end
    end

    // transitions
    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        if (clr) begin
            state_d = ST_DATA;
            cnt_d   = '0;
        end else begin
            unique case (state_q)
                ST_IDLE: begin
                end
                ST_DATA: begin
                    if (accept) begin
                        if (cnt_q == CNT_W'(NLEN-1)) begin
                            cnt_d   = '0;
                            state_d = gen_mode ? ST_DONE : ST_PARITY;
                        end else begin
                            cnt_d = cnt_q + CNT_W'(1);
                        end
                    end
                end
                ST_PARITY: begin
                    if (accept) begin
                        if (cnt_q == CNT_W'(NB-1)) begin
                            cnt_d   = '0;
                            state_d = ST_FEED;
                        end else begin
                            cnt_d = cnt_q + CNT_W'(1);
                        end
                    end
                end
                ST_FEED: begin
                    if (enable) begin
                        if (cnt_q == CNT_W'(NP-1)) begin
                            cnt_d   = '0;
                            state_d = ST_DONE;
                        end else begin
                            cnt_d = cnt_q + CNT_W'(1);
                        end
                    end
                end
                ST_DONE: begin
                end
                default: state_d = ST_IDLE;
            endcase
        end
    end

    // outputs
    always_comb begin
        shift_en    = 1'b0;
        feed_parity = 1'b0;
        pbuf_we     = 1'b0;
        unique case (state_q)
            ST_DATA:   shift_en = accept;
            ST_PARITY: pbuf_we = accept;
            ST_FEED: begin
                shift_en    = enable;
                feed_parity = 1'b1;
            end
            default: begin
            end
        endcase
        if (clr) begin
            shift_en = 1'b0;
            pbuf_we  = 1'b0;
        end
    end

    assign done     = (state_q == ST_DONE);
    assign byte_idx = cnt_q[BI_W-1:0];
    assign slot_idx = cnt_q[SI_W-1:0];

    AST_GEN_SKIPS_PARITY: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_DATA && gen_mode && !clr) |=> (state_q == ST_DATA || state_q == ST_DONE)); // R5
    AST_DONE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_DONE && !clr) |=> (state_q == ST_DONE)); // R5
    AST_FROZEN_STATE: assert property (@(posedge clk) disable iff (!rst_n)
        (!enable && !clr) |=> ($stable(state_q) && $stable(cnt_q))); // R6
    AST_PARITY_COUNT: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_PARITY) |-> (cnt_q < CNT_W'(NB))); // R7
endmodule

// File: rtl/rs10_parity_engine.sv
module rs10_parity_engine
    import rsp_pkg::*;
#(
    parameter int W = SYM_W,
    parameter int NP = NPAR,
    parameter int NLEN = DATA_LEN,
    parameter int ADDR_W = 4,
    parameter int REG_W = 16,
    localparam int NB = ECC_BYTES,
    localparam int BI_W = $clog2(NB),
    localparam int SI_W = $clog2(NP),
    localparam int A_CTRL = 0,
    localparam int A_STAT = 1,
    localparam int A_REM = 2,
    localparam int A_ECC = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              byte_valid,
    input  logic [7:0]        byte_data,
    input  logic              reg_we,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [REG_W-1:0]  reg_wdata,
    output logic [REG_W-1:0]  reg_rdata
);
    logic en_q, gen_q, mode_q;
    logic ctrl_wr, clr;
    logic shift_en, feed_parity, pbuf_we, done, err;
    logic [BI_W-1:0] byte_idx;
    logic [SI_W-1:0] slot_idx;
    logic [W-1:0] slot_sym, sym_in;
    logic [NP-1:0][W-1:0] rem;
    logic [NB-1:0][7:0] ecc;
    logic unused_wdata;

    assign unused_wdata = ^reg_wdata[REG_W-1:3];
    assign ctrl_wr = reg_we && (reg_addr == ADDR_W'(A_CTRL));
    assign clr     = ctrl_wr && reg_wdata[2];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            en_q   <= 1'b0;
            gen_q  <= 1'b0;
            mode_q <= 1'b0;
        end else if (ctrl_wr) begin
            en_q  <= reg_wdata[0];
            gen_q <= reg_wdata[1];
            if (reg_wdata[2]) mode_q <= reg_wdata[1];
        end
    end

    rsp_ctrl #(.NLEN(NLEN), .NP(NP), .NB(NB)) u_ctrl (
        .clk(clk), .rst_n(rst_n), .clr(clr), .enable(en_q), .gen_mode(mode_q),
        .byte_valid(byte_valid), .shift_en(shift_en), .feed_parity(feed_parity),
        .pbuf_we(pbuf_we), .done(done), .byte_idx(byte_idx), .slot_idx(slot_idx)
    );

    rsp_parity_buf #(.W(W), .NP(NP), .NB(NB)) u_pbuf (
        .clk(clk), .rst_n(rst_n), .clr(clr), .we(pbuf_we), .byte_idx(byte_idx),
        .byte_in(byte_data), .slot_idx(slot_idx), .slot_sym(slot_sym)
    );

    assign sym_in = feed_parity ? slot_sym : W'(byte_data);

    rsp_divider #(.W(W), .NP(NP)) u_div (
        .clk(clk), .rst_n(rst_n), .clr(clr), .shift_en(shift_en),
        .sym_in(sym_in), .rem(rem)
    );

    rsp_packer #(.W(W), .NP(NP), .NB(NB)) u_pack (
        .rem(rem), .ecc_out(ecc)
    );

    assign err = done && !mode_q && (rem != '0);

    always_comb begin
        reg_rdata = '0;
        if (reg_addr == ADDR_W'(A_CTRL)) begin
            reg_rdata[1:0] = {gen_q, en_q};
        end
        if (reg_addr == ADDR_W'(A_STAT)) begin
            reg_rdata[1:0] = {done, err};
        end
        for (int k = 0; k < NP; k++) begin
            if (reg_addr == ADDR_W'(A_REM + k)) reg_rdata[W-1:0] = rem[k];
        end
        for (int b = 0; b < NB; b++) begin
            if (reg_addr == ADDR_W'(A_ECC + b)) reg_rdata[7:0] = ecc[b];
        end
    end

    AST_ECC_UPPER_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_addr >= ADDR_W'(A_ECC)) |-> (reg_rdata[REG_W-1:8] == '0)); // R4
    AST_DONE_REM_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !clr) |=> $stable(rem)); // R5
    if (NB * 8 - NP * W == 4) begin : g_pad_chk
        AST_PAD_ONES: assert property (@(posedge clk) disable iff (!rst_n)
            (reg_addr == ADDR_W'(A_ECC + NB - 1)) |-> (reg_rdata[3:0] == 4'hF)); // R4
    end
endmodule

// File: tb/rs10_parity_engine_bench.sv
module rs10_parity_engine_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        byte_valid = 1'b0;
    logic [7:0]  byte_data = '0;
    logic        reg_we = 1'b0;
    logic [3:0]  reg_addr = '0;
    logic [15:0] reg_wdata = '0;
    logic [15:0] reg_rdata;

    always #4 clk = ~clk;

    rs10_parity_engine u_rs10_parity_engine (
        .clk(clk), .rst_n(rst_n), .byte_valid(byte_valid), .byte_data(byte_data),
        .reg_we(reg_we), .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata)
    );

    int n_checks = 0;
    int n_fail = 0;
    logic [9:0]  gc [0:6];
    logic [7:0]  data [0:511];
    logic [9:0]  work [0:527];
    logic [9:0]  exp_rem [0:5];
    logic [7:0]  exp_ecc [0:7];
    logic [7:0]  rx_ecc [0:7];
    logic [15:0] rv;

    function automatic logic [9:0] fmul(logic [9:0] a, logic [9:0] b);
        logic [19:0] p = '0;
        for (int i = 0; i < 10; i++) if (b[i]) p = p ^ (20'(a) << i);
        for (int i = 19; i >= 10; i--) if (p[i]) p = p ^ (20'h409 << (i - 10));
        return p[9:0];
    endfunction

    function automatic logic [7:0] rv8(logic [7:0] b);
        logic [7:0] r;
        for (int i = 0; i < 8; i++) r[i] = b[7-i];
        return r;
    endfunction

    task automatic check(input string req, input string what, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
        end
    endtask

    // remainder of (work[0..n-1] as polynomial, first = highest) * x^6 mod g
    task automatic divide(input int n);
        logic [9:0] q;
        for (int i = n; i < n + 6; i++) work[i] = '0;
        for (int i = 0; i < n; i++) begin
            q = work[i];
            for (int j = 1; j <= 6; j++) work[i+j] = work[i+j] ^ fmul(q, gc[6-j]);
        end
        for (int k = 0; k < 6; k++) exp_rem[k] = work[n+5-k];
    endtask

    task automatic model_data(input int n);
        for (int i = 0; i < n; i++) work[i] = {2'b00, data[i]};
        divide(n);
    endtask

    task automatic make_ecc();
        logic [63:0] p;
        for (int j = 0; j < 6; j++) p[j*10 +: 10] = exp_rem[5-j];
        p[63:60] = 4'hF;
        for (int i = 0; i < 8; i++) exp_ecc[i] = rv8(p[i*8 +: 8]);
    endtask

    task automatic wr(input logic [3:0] a, input logic [15:0] d);
        @(negedge clk);
        reg_we = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_we = 1'b0; reg_wdata = '0;
    endtask

    task automatic rd(input logic [3:0] a, output logic [15:0] v);
        @(negedge clk);
        reg_addr = a;
        #1 v = reg_rdata;
    endtask

    task automatic stream(input int from, input int upto);
        for (int i = from; i < upto; i++) begin
            @(negedge clk);
            byte_valid = 1'b1; byte_data = data[i];
        end
        @(negedge clk);
        byte_valid = 1'b0;
    endtask

    task automatic send_rx();
        for (int i = 0; i < 8; i++) begin
            @(negedge clk);
            byte_valid = 1'b1; byte_data = rx_ecc[i];
        end
        @(negedge clk);
        byte_valid = 1'b0;
    endtask

    task automatic wait_done();
        for (int i = 0; i < 30; i++) begin
            rd(4'd1, rv);
            if (rv[1]) break;
        end
    endtask

    task automatic check_rem(input string req);
        for (int k = 0; k < 6; k++) begin
            rd(4'(2 + k), rv);
            check(req, $sformatf("remainder x^%0d", k), rv, exp_rem[k]);
        end
    endtask

    task automatic check_ecc(input string req);
        for (int b = 0; b < 8; b++) begin
            rd(4'(8 + b), rv);
            check(req, $sformatf("ecc byte %0d", b), rv, exp_ecc[b]);
        end
    endtask

    task automatic run_gen(input string tag);
        wr(4'd0, 16'h0007);
        stream(0, 512);
        model_data(512);
        make_ecc();
        check_rem({"R3 ", tag});
        check_ecc({"R4 ", tag});
        rd(4'd1, rv);
        check("R5", {"done after sector ", tag}, rv, 16'h0002);
    endtask

    // check mode: data[] and rx_ecc[] as received
    task automatic run_check(input string req, input string tag, input int exp_err);
        logic [63:0] p;
        wr(4'd0, 16'h0005);
        stream(0, 512);
        send_rx();
        wait_done();
        for (int i = 0; i < 512; i++) work[i] = {2'b00, data[i]};
        for (int i = 0; i < 8; i++) p[i*8 +: 8] = rv8(rx_ecc[i]);
        for (int j = 0; j < 6; j++) work[512+j] = p[j*10 +: 10];
        divide(518);
        check_rem({"R7 ", tag});
        rd(4'd1, rv);
        check(req, {"status ", tag}, rv, {14'b0, 1'b1, exp_err[0]});
    endtask

    task automatic fill_random();
        for (int i = 0; i < 512; i++) data[i] = 8'($urandom);
    endtask

    task automatic encode_for_rx();
        model_data(512);
        make_ecc();
        for (int i = 0; i < 8; i++) rx_ecc[i] = exp_ecc[i];
    endtask

    initial begin
        #(8 * 150000);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        int seed_v;
        int pos;
        logic [9:0] root;
        seed_v = $urandom(32'd7311);
        // generator coefficients
        for (int j = 0; j <= 6; j++) gc[j] = '0;
        gc[0] = 10'd1;
        root = 10'd1;
        for (int i = 0; i < 6; i++) begin
            for (int j = 6; j > 0; j--) gc[j] = gc[j-1] ^ fmul(gc[j], root);
            gc[0] = fmul(gc[0], root);
            root = fmul(root, 10'd2);
        end

        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        rd(4'd0, rv); check("R1", "control after reset", rv, 0);
        rd(4'd1, rv); check("R1", "status after reset", rv, 0);
        for (int k = 0; k < 6; k++) exp_rem[k] = '0;
        make_ecc();
        check_rem("R1 reset");
        check_ecc("R1 reset");

        // directed sectors
        for (int i = 0; i < 512; i++) data[i] = 8'h00;
        run_gen("zeros");
        for (int i = 0; i < 512; i++) data[i] = 8'hFF;
        run_gen("ones");
        for (int i = 0; i < 512; i++) data[i] = 8'h00;
        data[0] = 8'h01;
        run_gen("first byte");
        data[0] = 8'h00; data[511] = 8'h80;
        run_gen("last byte");
        for (int t = 0; t < 4; t++) begin
            fill_random();
            run_gen("random");
        end
        rd(4'd0, rv); check("R2", "control readback", rv, 16'h0003);

        // R5 extra strobes after done
        stream(0, 5);
        check_rem("R5 extra strobes");
        rd(4'd1, rv); check("R5", "still done", rv, 16'h0002);

        // R2 clear mid-sector
        fill_random();
        wr(4'd0, 16'h0007);
        stream(0, 100);
        wr(4'd0, 16'h0007);
        for (int k = 0; k < 6; k++) exp_rem[k] = '0;
        check_rem("R2 clear");
        rd(4'd1, rv); check("R2", "not done after clear", rv, 0);
        stream(0, 512);
        model_data(512);
        check_rem("R2 restart count");

        // R6 freeze and resume
        fill_random();
        wr(4'd0, 16'h0007);
        stream(0, 200);
        wr(4'd0, 16'h0000);
        stream(300, 350);
        model_data(200);
        check_rem("R6 frozen");
        rd(4'd1, rv); check("R6", "not done while frozen", rv, 0);
        wr(4'd0, 16'h0003);
        stream(200, 512);
        model_data(512);
        check_rem("R6 resumed");

        // R7 valid codewords
        for (int t = 0; t < 2; t++) begin
            fill_random();
            encode_for_rx();
            run_check("R7", "valid", 0);
        end

        // R9 pad nibble ignored
        fill_random();
        encode_for_rx();
        rx_ecc[7] = rx_ecc[7] ^ 8'h0A;
        run_check("R9", "pad changed", 0);

        // R8 data errors
        for (int t = 0; t < 3; t++) begin
            fill_random();
            encode_for_rx();
            pos = (t == 0) ? 0 : (t == 1) ? 511 : int'($urandom_range(1, 510));
            data[pos] = data[pos] ^ 8'(($urandom % 255) + 1);
            run_check("R8", $sformatf("data error at %0d", pos), 1);
        end

        // R8 parity errors
        fill_random();
        encode_for_rx();
        rx_ecc[0] = rx_ecc[0] ^ 8'h01;
        run_check("R8", "parity byte 0 error", 1);
        fill_random();
        encode_for_rx();
        rx_ecc[7] = rx_ecc[7] ^ 8'h10;
        run_check("R8", "parity byte 7 error", 1);

        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end
endmodule